// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase outputs of an incremental encoder into a 32-bit position count. Both phase inputs are first brought into the system clock domain through two-flop synchronisers. A decoder then qualifies their edges according to one of four counting modes and produces a single step together with the step's direction. The step moves a position counter that runs between 0 and a programmable ceiling and wraps at both ends. The direction of the most recent step is kept as a status bit.

Wrap-arounds and changes of direction are reported as events. Each event sets a sticky flag that stays set until software clears it by writing a one. An enable mask decides which events may raise a global flag, and that global flag drives the interrupt pin.

Software reaches the count, the ceiling, the control fields, the status, the mask and the flags through a small single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. This port is plain control, so it has no valid/ready handshake and no back-pressure. The encoder pins are sampled on every clock with no handshake.

Register map (word addresses): 0 position count, 1 ceiling (resets to all ones), 2 control, 3 status, 4 event enable mask, 5 event flags (read only), 6 flag clear (write only, reads 0).

Top module: `qenc_pos_counter`

## Requirements
- R1: Control register layout: bit 0 enables counting, bits 2:1 select the source mode (0 quadrature, 1 direction-count, 2 up-count, 3 down-count), and bit 3 selects both-edge counting. The register reads back exactly as written.
- R2: In quadrature mode every single-bit change of the {A,B} pair produces one step, giving four steps per encoder cycle. The forward order is 00, 10, 11, 01, 00; the opposite order counts backward.
- R3: In quadrature mode, a transition where A and B change in the same sample produces no step.
- R4: In direction-count mode only rising edges of A produce a step. The step is forward when B is 1 and backward when B is 0.
- R5: Up-count mode steps forward and down-count mode steps backward, on A only, with B ignored. With control bit 3 set, both edges of A count; with it clear, only rising edges count.
- R6: A software write to the position count takes effect only when the value is not above the ceiling. A larger value leaves the count unchanged.
- R7: A forward step taken at or above the ceiling wraps the count to 0 and sets the overflow flag (bit 6).
- R8: A backward step taken at 0 loads the ceiling into the count and sets the underflow flag (bit 5).
- R9: While the enable bit is clear, encoder activity leaves the count and the direction unchanged.
- R10: Status bit 5 is 1 when the last step was forward and 0 when it was backward. It resets to 1.
- R11: The enable mask, flag and clear registers share one layout: bit 3 is direction change, bit 5 underflow, bit 6 overflow, and bit 0 the global flag. Event flags are sticky whatever the mask says. Writing 1 to a clear bit clears that flag, and writing 0 leaves it unchanged.
- R12: The global flag (flag bit 0) is set when an event whose mask bit is set occurs. It stays set until bit 0 of the clear register is written with 1, and the `irq` output equals it.
- R13: An encoder input change that is driven before clock edge k shows up in the count, the status and the flags right after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt, equal to the global flag |

## Verification
An encoder change lands after three rising edges: two synchroniser stages and then the counter and flag registers, which all update on the same edge. The bench drives A and B at a falling edge. It reads the count one time unit after the second rising edge to confirm nothing has moved yet. It then reads count, status, flags and the interrupt at the falling edge after the third rising edge. Register writes take effect on the single rising edge that follows them, so every readback is taken at the next falling edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int ADDR_W = 3;
  localparam int EV_W   = 12;

  localparam logic [ADDR_W-1:0] RA_COUNT  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CEIL   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] RA_MASK   = 3'd4;
  localparam logic [ADDR_W-1:0] RA_FLAGS  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_CLEAR  = 3'd6;

  localparam int EVB_GLOBAL = 0;
  localparam int EVB_DIRCHG = 3;
  localparam int EVB_UNDER  = 5;
  localparam int EVB_OVER   = 6;
  localparam int STS_DIR    = 5;
  localparam int CTRL_W     = 4;

  localparam logic [EV_W-1:0] EV_SRC_MASK =
    EV_W'((1 << EVB_DIRCHG) | (1 << EVB_UNDER) | (1 << EVB_OVER));

  typedef enum logic [1:0] {
    SRC_QUAD   = 2'd0,
    SRC_DIRCNT = 2'd1,
    SRC_UP     = 2'd2,
    SRC_DOWN   = 2'd3
  } src_mode_e;

  typedef struct packed {
    logic      both_edges;
    src_mode_e src;
    logic      run;
  } ctrl_t;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a_s,
  input  logic      b_s,
  input  src_mode_e src,
  input  logic      both_edges,
  input  logic      run,
  output logic      step,
  output logic      step_up
);

  logic a_prev, b_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a_s;
      b_prev <= b_s;
    end
  end

  logic a_chg, b_chg, a_rise, a_qual, raw_step;
  assign a_chg  = a_s ^ a_prev;
  assign b_chg  = b_s ^ b_prev;
  assign a_rise = a_s & ~a_prev;
  assign a_qual = both_edges ? a_chg : a_rise;

  always_comb begin
    raw_step = 1'b0;
    step_up  = 1'b1;
    unique case (src)
      SRC_QUAD: begin
        raw_step = a_chg ^ b_chg;
        step_up  = b_prev ^ a_s;
      end
      SRC_DIRCNT: begin
        raw_step = a_rise;
        step_up  = b_s;
      end
      SRC_UP: begin
        raw_step = a_qual;
        step_up  = 1'b1;
      end
      SRC_DOWN: begin
        raw_step = a_qual;
        step_up  = 1'b0;
      end
      default: begin
        raw_step = 1'b0;
        step_up  = 1'b1;
      end
    endcase
  end

  assign step = run & raw_step;

endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_up,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] ceil_val,
  output logic [CNT_W-1:0] count,
  output logic             dir_fwd,
  output logic             ev_over,
  output logic             ev_under,
  output logic             ev_dirchg
);

  logic wr_ok, adv, at_top, at_zero;
  assign wr_ok   = wr_req & (wr_val <= ceil_val);
  assign adv     = step & ~wr_ok;
  assign at_top  = count >= ceil_val;
  assign at_zero = count == '0;

  assign ev_over   = adv &  step_up & at_top;
  assign ev_under  = adv & ~step_up & at_zero;
  assign ev_dirchg = adv & (step_up != dir_fwd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      dir_fwd <= 1'b1;
    end else if (wr_ok) begin
      count <= wr_val;
    end else if (adv) begin
      dir_fwd <= step_up;
      if (step_up) count <= at_top  ? '0       : count + 1'b1;
      else         count <= at_zero ? ceil_val : count - 1'b1;
    end
  end

endmodule

// File: rtl/qenc_events.sv
module qenc_events
  import qenc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_pulse,
  input  logic [EV_W-1:0] ev_mask,
  input  logic            clr_wr,
  input  logic [EV_W-1:0] clr_bits,
  output logic [EV_W-1:0] flags,
  output logic            irq
);

  logic hit;
  assign hit = |(ev_pulse & ev_mask & EV_SRC_MASK);

  for (genvar i = 0; i < EV_W; i++) begin : g_flag
    if (i == EVB_GLOBAL) begin : g_glb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= hit | (flags[i] & ~(clr_wr & clr_bits[i]));
      end
    end else if (EV_SRC_MASK[i]) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= ev_pulse[i] | (flags[i] & ~(clr_wr & clr_bits[i]));
      end
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end

  assign irq = flags[EVB_GLOBAL];

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);

  logic [1:0]       ab_s;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] ceil_q;
  logic [EV_W-1:0]  mask_q;
  logic [CNT_W-1:0] pos_count;
  logic             dir_fwd;
  logic             dec_step, dec_up;
  logic             ev_over, ev_under, ev_dirchg;
  logic [EV_W-1:0]  ev_vec, flags_q;
  logic             cnt_wr, clr_wr;

  assign cnt_wr = reg_wr && (reg_addr == RA_COUNT);
  assign clr_wr = reg_wr && (reg_addr == RA_CLEAR);

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b}), .q(ab_s)
  );

  qenc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .a_s(ab_s[1]), .b_s(ab_s[0]),
    .src(ctrl_q.src), .both_edges(ctrl_q.both_edges), .run(ctrl_q.run),
    .step(dec_step), .step_up(dec_up)
  );

  qenc_poscnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(dec_step), .step_up(dec_up),
    .wr_req(cnt_wr), .wr_val(reg_wdata), .ceil_val(ceil_q),
    .count(pos_count), .dir_fwd(dir_fwd),
    .ev_over(ev_over), .ev_under(ev_under), .ev_dirchg(ev_dirchg)
  );

  always_comb begin
    ev_vec             = '0;
    ev_vec[EVB_OVER]   = ev_over;
    ev_vec[EVB_UNDER]  = ev_under;
    ev_vec[EVB_DIRCHG] = ev_dirchg;
  end

  qenc_events u_ev (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_vec), .ev_mask(mask_q),
    .clr_wr(clr_wr), .clr_bits(reg_wdata[EV_W-1:0]),
    .flags(flags_q), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ceil_q <= '1;
      mask_q <= '0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        RA_CTRL: ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RA_CEIL: ceil_q <= reg_wdata;
        RA_MASK: mask_q <= reg_wdata[EV_W-1:0] & EV_SRC_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_COUNT:  reg_rdata = pos_count;
      RA_CEIL:   reg_rdata = ceil_q;
      RA_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
      RA_STATUS: reg_rdata[STS_DIR] = dir_fwd;
      RA_MASK:   reg_rdata[EV_W-1:0] = mask_q;
      RA_FLAGS:  reg_rdata[EV_W-1:0] = flags_q;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/qenc_pos_counter_chk.sv
module qenc_pos_counter_chk
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic              irq,
  input logic              run,
  input logic [CNT_W-1:0]  pos_count,
  input logic [CNT_W-1:0]  ceil_q,
  input logic              ev_over,
  input logic              ev_under,
  input logic [EV_W-1:0]  flags_q
);

  a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(reg_wr && reg_addr == RA_COUNT)) |=> $stable(pos_count));

  a_r7_overflow_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ev_over |=> (pos_count == '0) && flags_q[EVB_OVER]);

  a_r8_underflow_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ev_under |=> (pos_count == $past(ceil_q)) && flags_q[EVB_UNDER]);

  a_r6_write_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_COUNT && reg_wdata <= ceil_q) |=> pos_count == $past(reg_wdata));

  a_r12_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == RA_CLEAR && reg_wdata[EVB_GLOBAL])) |=> irq);

  a_r11_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_CLEAR && reg_wdata[EVB_OVER] && !ev_over) |=> !flags_q[EVB_OVER]);

endmodule

bind qenc_pos_counter qenc_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .run(ctrl_q.run), .pos_count(pos_count),
  .ceil_q(ceil_q), .ev_over(ev_over), .ev_under(ev_under), .flags_q(flags_q)
);

// File: tb/tb_qenc_pos_counter.sv
module tb_qenc_pos_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  qenc_pos_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] m_cnt = 0, m_ceil = 32'hFFFF_FFFF, m_flags = 0, m_mask = 0;
  bit m_dir = 1, m_glb = 0, m_run = 0, m_both = 0;
  int m_mode = 0;
  bit cur_a = 0, cur_b = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      3'd0: if (d <= m_ceil) m_cnt = d;
      3'd1: m_ceil = d;
      3'd2: begin m_run = d[0]; m_mode = int'(d[2:1]); m_both = d[3]; end
      3'd4: m_mask = d & 32'h68;
      3'd6: begin m_flags = m_flags & ~(d & 32'h68); if (d[0]) m_glb = 0; end
      default: ;
    endcase
  endtask

  function automatic int model_step(bit pa, bit pb, bit na, bit nb, int mode, bit both);
    bit ae;
    case (mode)
      0: if ((pa ^ na) != (pb ^ nb)) return (pb ^ na) ? 1 : -1;
         else return 0;
      1: if (!pa && na) return nb ? 1 : -1;
         else return 0;
      2: begin ae = both ? (pa ^ na) : (!pa && na); return ae ? 1 : 0; end
      default: begin ae = both ? (pa ^ na) : (!pa && na); return ae ? -1 : 0; end
    endcase
  endfunction

  function automatic string mode_req(int mode);
    case (mode)
      0: return "R2";
      1: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_all(string req);
    logic [31:0] v;
    rd(3'd0, v); chk(req, "count", v, m_cnt);
    rd(3'd3, v); chk("R10", "status", v, {26'd0, m_dir, 5'd0});
    rd(3'd5, v); chk("R11", "flags", v, m_flags | {31'd0, m_glb});
    chk("R12", "irq", {31'd0, irq}, {31'd0, m_glb});
  endtask

  task automatic move(bit na, bit nb, string req);
    int s;
    bit up;
    logic [31:0] ev, v, old;
    old = m_cnt;
    @(negedge clk);
    enc_a = na; enc_b = nb;
    @(posedge clk); @(posedge clk);
    rd(3'd0, v); chk("R13", "count before third edge", v, old);
    @(posedge clk);
    @(negedge clk);
    s = model_step(cur_a, cur_b, na, nb, m_mode, m_both);
    cur_a = na; cur_b = nb;
    if (m_run && s != 0) begin
      up = (s > 0);
      ev = 0;
      if (up) begin
        if (m_cnt >= m_ceil) begin m_cnt = 0; ev = 32'h40; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_cnt = m_ceil; ev = 32'h20; end
        else m_cnt = m_cnt - 1;
      end
      if (up != m_dir) ev = ev | 32'h08;
      m_dir = up;
      m_flags = m_flags | ev;
      if ((ev & m_mask) != 0) m_glb = 1;
    end
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check_all("R10");
    rd(3'd1, v); chk("R6", "reset ceiling", v, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R1", "reset ctrl", v, 32'h0);

    // R1 control layout readback
    wr(3'd2, 32'hB);
    rd(3'd2, v); chk("R1", "ctrl readback", v, 32'hB);
    wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R1", "ctrl quad run", v, 32'h1);

    // R2 forward quadrature, four steps per cycle
    move(1, 0, "R2"); move(1, 1, "R2"); move(0, 1, "R2"); move(0, 0, "R2");
    chk("R2", "four counts per cycle", m_cnt, 32'd4);
    // backward
    move(0, 1, "R2"); move(1, 1, "R2");
    // R3 illegal double change
    move(0, 0, "R3");
    chk("R3", "illegal jump held", m_cnt, 32'd2);

    // R6 write acceptance against ceiling
    wr(3'd1, 32'd10);
    wr(3'd0, 32'd11);
    rd(3'd0, v); chk("R6", "over-ceiling write rejected", v, 32'd2);
    wr(3'd0, 32'd10);
    rd(3'd0, v); chk("R6", "write accepted", v, 32'd10);

    // R7 overflow with mask set -> R12 irq
    wr(3'd4, 32'h40);
    move(1, 0, "R7");
    chk("R7", "wrap to zero", m_cnt, 32'd0);
    rd(3'd5, v); chk("R7", "overflow flag", v & 32'h40, 32'h40);
    chk("R12", "irq raised", {31'd0, irq}, 32'd1);
    // R11 clear overflow only, irq stays
    wr(3'd6, 32'h40);
    rd(3'd5, v); chk("R11", "overflow cleared", v & 32'h40, 32'h0);
    chk("R12", "irq still set", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h1);
    chk("R12", "irq cleared", {31'd0, irq}, 32'd0);

    // R8 underflow, unmasked: flag but no irq
    move(0, 0, "R8");
    chk("R8", "wrap to ceiling", m_cnt, 32'd10);
    rd(3'd5, v); chk("R8", "underflow flag", v & 32'h20, 32'h20);
    chk("R12", "masked event leaves irq low", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h0);
    rd(3'd5, v); chk("R11", "zero clear keeps flags", v & 32'h28, 32'h28);
    wr(3'd6, 32'h69);

    // R9 disabled
    wr(3'd2, 32'h0);
    move(1, 0, "R9"); move(1, 1, "R9");
    chk("R9", "held while disabled", m_cnt, 32'd10);

    // R4 direction-count
    wr(3'd2, 32'h3);
    move(0, 1, "R4"); move(1, 1, "R4"); move(0, 0, "R4"); move(1, 0, "R4");
    // R5 up with rising only, B ignored, then both edges; down mode
    wr(3'd2, 32'h5);
    move(0, 0, "R5"); move(0, 1, "R5"); move(1, 1, "R5");
    wr(3'd2, 32'hD);
    move(0, 1, "R5"); move(1, 1, "R5");
    wr(3'd2, 32'h7);
    move(0, 1, "R5"); move(1, 1, "R5");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 13) begin
        int k;
        k = int'($urandom % 8);
        if (k < 3)      move(!cur_a, cur_b, mode_req(m_mode));
        else if (k < 6) move(cur_a, !cur_b, mode_req(m_mode));
        else if (k == 6) move(!cur_a, !cur_b, (m_mode == 0) ? "R3" : mode_req(m_mode));
        else            move(cur_a, cur_b, mode_req(m_mode));
      end else if (r < 15) begin
        wr(3'd2, {28'd0, 4'($urandom)} | ((($urandom % 5) != 0) ? 32'h1 : 32'h0));
        rd(3'd2, v); chk("R1", "ctrl readback", v, {28'd0, m_both, 2'(m_mode), m_run});
      end else if (r == 15) begin
        wr(3'd1, 32'd3 + ($urandom % 13));
      end else if (r == 16) begin
        wr(3'd6, $urandom & 32'h69);
        check_all("R11");
      end else if (r == 17) begin
        wr(3'd0, $urandom % 20);
        check_all("R6");
      end else begin
        wr(3'd4, $urandom);
        rd(3'd4, v); chk("R11", "mask readback", v, m_mask);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule